// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds the program-visible general registers of a processor datapath. It stores fifteen words and serves three accesses at once: two independent read ports and one write port. Each port has its own 4-bit register identifier and its own data bus. The data on a read port follows its identifier combinationally. A write is taken at the rising clock edge.

The all-ones identifier (15 with the default width) is reserved to mean "no register". A read port given that identifier returns zero, and a write aimed at it is discarded. Several ports may name the same register in one cycle. A read that names the register being written in that cycle sees the old contents until the clock edge has passed. Nothing is forwarded from the write bus to a read bus.

An asynchronous active-low reset clears every register to zero. Its release is synchronised inside the block, so writes take effect from the third rising edge after `rst_n` goes high.

Top module: `regfile_2r1w`

## Requirements
- R1: While reset is asserted, and after it is released, every register 0 to 14 reads as zero on both ports until it is written.
- R2: Read port A returns the contents of the register named by `rd_a_id` combinationally, with no clock edge between an identifier change and the new data.
- R3: Read port B works the same way as port A, independently of port A's identifier.
- R4: A write of `wr_data` to register `wr_id` (0 to 14) becomes visible on the read ports just after the rising edge that takes it, and not before.
- R5: A write with `wr_id` equal to 15 leaves all registers unchanged.
- R6: A read port whose identifier is 15 drives all zeros on its data output.
- R7: When a read identifier equals the write identifier in the same cycle, that read returns the pre-edge contents; there is no write-through.
- R8: Both read ports may name the same register, or different registers, in the same cycle as a write, and each returns that register's contents.
- R9: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_id | input | 4 | Register identifier for read port A; 15 means no read |
| rd_a_data | output | 64 | Data of read port A |
| rd_b_id | input | 4 | Register identifier for read port B; 15 means no read |
| rd_b_data | output | 64 | Data of read port B |
| wr_id | input | 4 | Register identifier for the write port; 15 means no write |
| wr_data | input | 64 | Word written at the rising edge |

## Verification
The bench builds the block with its default parameters: 64-bit words and 4-bit identifiers, which gives fifteen registers and the reserved identifier 15. With these values the topmost real register 14, the null identifier on each of the three ports, and an all-ones data word are all within reach. A full sweep of all fifteen registers is short enough to run after every stimulus phase. The stimulus table places reads of the register being written in the same cycle, so the pre-edge ordering is checked on both read ports.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DATA_W = 64;
  localparam int RF_ID_W   = 4;

  typedef logic [RF_DATA_W-1:0] rf_word_t;
  typedef logic [RF_ID_W-1:0]   rf_id_t;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int ID_W = rf_pkg::RF_ID_W,
  localparam int NUM_REGS = (1 << ID_W) - 1
) (
  input  logic [ID_W-1:0]     wr_id,
  output logic [NUM_REGS-1:0] wr_en
);
  // The all-ones identifier matches no slot, so it enables nothing.
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_dec
    assign wr_en[gi] = (wr_id == ID_W'(gi));
  end
endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int DATA_W = rf_pkg::RF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] word_q
);
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (wr_en) begin
      word_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ID_W   = rf_pkg::RF_ID_W,
  localparam int NUM_REGS = (1 << ID_W) - 1
) (
  input  logic [ID_W-1:0]   rd_id,
  input  logic [DATA_W-1:0] words [NUM_REGS],
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_id == ID_W'(i)) begin
        rd_data = words[i];
      end
    end
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ID_W   = rf_pkg::RF_ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NUM_REGS = (1 << ID_W) - 1;
  localparam int NUM_RD   = 2;

  logic                rst_sync_n;
  logic [NUM_REGS-1:0] wr_en;
  logic [DATA_W-1:0]   words [NUM_REGS];
  logic [ID_W-1:0]     rd_ids  [NUM_RD];
  logic [DATA_W-1:0]   rd_datas[NUM_RD];

  rf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rf_wr_decode #(.ID_W(ID_W)) u_wr_decode (
    .wr_id (wr_id),
    .wr_en (wr_en)
  );

  for (genvar gr = 0; gr < NUM_REGS; gr++) begin : g_word
    rf_word #(.DATA_W(DATA_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_en[gr]),
      .wr_data (wr_data),
      .word_q  (words[gr])
    );
  end

  assign rd_ids[0] = rd_a_id;
  assign rd_ids[1] = rd_b_id;

  for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_rd
    rf_rd_port #(.DATA_W(DATA_W), .ID_W(ID_W)) u_rd (
      .rd_id   (rd_ids[gp]),
      .words   (words),
      .rd_data (rd_datas[gp])
    );
  end

  assign rd_a_data = rd_datas[0];
  assign rd_b_data = rd_datas[1];
endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ID_W   = rf_pkg::RF_ID_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ID_W-1:0]   rd_a_id,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ID_W-1:0]   rd_b_id,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [ID_W-1:0]   wr_id,
  input logic [DATA_W-1:0] wr_data
);
  localparam logic [ID_W-1:0] NULL_ID = '1;

  AST_NULL_READ_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_a_id == NULL_ID) |-> (rd_a_data == '0)); // R6
  AST_NULL_READ_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_b_id == NULL_ID) |-> (rd_b_data == '0)); // R6
  AST_SAME_ID_AGREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data)); // R8
  AST_WRITE_SEEN_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_id != NULL_ID) |=> ((rd_a_id != $past(wr_id)) || (rd_a_data == $past(wr_data)))); // R4
  AST_WRITE_SEEN_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_id != NULL_ID) |=> ((rd_b_id != $past(wr_id)) || (rd_b_data == $past(wr_data)))); // R4
  AST_NULL_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_id == NULL_ID) |=> ((rd_a_id != $past(rd_a_id)) || $stable(rd_a_data))); // R5
endmodule

bind regfile_2r1w regfile_2r1w_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rd_a_id    (rd_a_id),
  .rd_a_data  (rd_a_data),
  .rd_b_id    (rd_b_id),
  .rd_b_data  (rd_b_data),
  .wr_id      (wr_id),
  .wr_data    (wr_data)
);

// File: tb/regfile_2r1w_bench.sv
module regfile_2r1w_bench;
  localparam int DW = 64;
  localparam int IW = 4;
  localparam int NROWS = 10;
  localparam logic [DW-1:0] ONES = '1;

  // Row: {wr_id, wr_data, rd_a_id, rd_b_id, expected A (pre-edge), expected B (pre-edge)}
  localparam logic [203:0] VEC [NROWS] = '{
    {4'd1,  64'h1111, 4'd1,  4'd2,  64'h0,    64'h0},
    {4'd2,  64'h2222, 4'd1,  4'd2,  64'h1111, 64'h0},
    {4'd15, 64'hDEAD, 4'd1,  4'd2,  64'h1111, 64'h2222},
    {4'd14, 64'hEEEE, 4'd15, 4'd2,  64'h0,    64'h2222},
    {4'd0,  64'hA0A0, 4'd14, 4'd15, 64'hEEEE, 64'h0},
    {4'd1,  64'hBBBB, 4'd0,  4'd1,  64'hA0A0, 64'h1111},
    {4'd15, 64'hFFFF, 4'd1,  4'd1,  64'hBBBB, 64'hBBBB},
    {4'd15, 64'h0,    4'd15, 4'd15, 64'h0,    64'h0},
    {4'd7,  ONES,     4'd7,  4'd14, 64'h0,    64'hEEEE},
    {4'd15, 64'h0,    4'd7,  4'd0,  ONES,     64'hA0A0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] rd_a_id, rd_b_id, wr_id;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  regfile_2r1w u_regfile_2r1w (
    .clk(clk), .rst_n(rst_n),
    .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
    .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
    .wr_id(wr_id), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] after_table(input int idx);
    case (idx)
      0:  return 64'hA0A0;
      1:  return 64'hBBBB;
      2:  return 64'h2222;
      7:  return ONES;
      14: return 64'hEEEE;
      default: return 64'h0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_id = 4'd15; wr_data = '0; rd_a_id = 4'd3; rd_b_id = 4'd9;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset port A", rd_a_data, '0);
    check("R1 reset port B", rd_b_data, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: R2 R3 R4 R6 R7 R8 R9
    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      wr_id   = VEC[r][203:200];
      wr_data = VEC[r][199:136];
      rd_a_id = VEC[r][135:132];
      rd_b_id = VEC[r][131:128];
      #1;
      check($sformatf("R7 R2 table row %0d port A", r), rd_a_data, VEC[r][127:64]);
      check($sformatf("R8 R3 table row %0d port B", r), rd_b_data, VEC[r][63:0]);
    end

    // R5 R9 sweep: null writes discarded, unwritten registers untouched
    @(negedge clk);
    wr_id = 4'd15; wr_data = 64'hBAD;
    @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      rd_a_id = IW'(i); rd_b_id = IW'(14 - i);
      #1;
      check($sformatf("R5 R9 sweep A reg %0d", i), rd_a_data, after_table(i));
      check($sformatf("R5 R9 sweep B reg %0d", 14 - i), rd_b_data, after_table(14 - i));
    end

    // R2: combinational follow without an edge
    @(negedge clk);
    rd_a_id = 4'd14; #0.5;
    check("R2 comb A reg14", rd_a_data, 64'hEEEE);
    rd_a_id = 4'd2; #0.5;
    check("R2 comb A reg2", rd_a_data, 64'h2222);
    rd_b_id = 4'd15; #0.5;
    check("R6 null read B", rd_b_data, '0);

    // R4 R7: write is invisible before the edge and visible after
    @(negedge clk);
    wr_id = 4'd3; wr_data = 64'h3333; rd_a_id = 4'd3; rd_b_id = 4'd3;
    #1;
    check("R7 pre-edge A", rd_a_data, '0);
    check("R7 pre-edge B", rd_b_data, '0);
    @(negedge clk);
    wr_id = 4'd15;
    #1;
    check("R4 post-edge A", rd_a_data, 64'h3333);
    check("R4 post-edge B", rd_b_data, 64'h3333);

    // R1: asynchronous reset clears everything
    @(negedge clk);
    rst_n = 1'b0; rd_a_id = 4'd1; rd_b_id = 4'd7;
    #1;
    check("R1 mid-run reset A", rd_a_data, '0);
    check("R1 mid-run reset B", rd_b_data, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr_id = 4'd5; wr_data = 64'h5555; rd_a_id = 4'd5; rd_b_id = 4'd3;
    @(negedge clk);
    wr_id = 4'd15;
    #1;
    check("R4 write after reset", rd_a_data, 64'h5555);
    check("R1 reg3 still clear", rd_b_data, '0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule